// File: doc/BRIEF.md
# Video Sync Lock Qualifier

This block decides whether an incoming video stream counts as locked. Two detectors outside the block each give a per-line lock opinion. One is fast and judges the horizontal sync window line by line. The other is slow and weighs several fields, including vertical sync. A select input picks which opinion is used. An optional enable can also require a separate color subcarrier lock input. Together these form the raw lock condition for each line.

The block applies hysteresis in units of video lines, which a single-cycle line strobe marks. Two 3-bit codes pick the entry and exit run lengths from a fixed eight-entry table: 1, 2, 5, 10, 100, 500, 1000 and 100000 lines. Entering lock needs an unbroken run of good lines of the entry length. Leaving lock needs an unbroken run of bad lines of the exit length. A two-bit status reports the qualified lock state and the raw condition of the last line. The suggested setting for both codes after power-up is 3'b100, which is 100 lines. Register storage for the codes lies outside this block.

Top module: `vsync_lock_qual`

## Requirements
- R1: While reset is held and after it is released, `lock_status` reads 2'b00 (unlocked, raw condition false) until a line strobe arrives.
- R2: The raw source is `slow_lock` when `src_fast` is 0 and `fast_lock` when `src_fast` is 1.
- R3: When `sc_need` is 0 the raw condition is the selected source alone. When `sc_need` is 1 it is the selected source AND `sc_lock`.
- R4: From the unlocked state, `lock_status[0]` becomes 1 after exactly N consecutive strobed lines with a true raw condition. It is still 0 after N-1 such lines. N comes from `enter_code` by the table 0→1, 1→2, 2→5, 3→10, 4→100, 5→500, 6→1000, 7→100000.
- R5: From the locked state, `lock_status[0]` becomes 0 after exactly N consecutive strobed lines with a false raw condition, with N from `exit_code` by the same table.
- R6: Cycles without `line_stb` change neither the lock state nor the progress of a pending run, whatever the other inputs are.
- R7: A line that breaks a pending run restarts it. A good line while unlocked, or a bad line while locked, must then be followed by a full N-line run.
- R8: `lock_status[1]` holds the raw condition of the most recent strobed line. It changes only on a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle pulse per video line |
| fast_lock | input | 1 | Line-by-line horizontal window lock indication |
| slow_lock | input | 1 | Multi-field free-run lock indication |
| src_fast | input | 1 | Raw source select: 1 fast, 0 slow |
| sc_need | input | 1 | Require color subcarrier lock as well |
| sc_lock | input | 1 | Color subcarrier lock indication |
| enter_code | input | 3 | Entry run-length code |
| exit_code | input | 3 | Exit run-length code |
| lock_status | output | 2 | Bit 1 raw condition of the last line, bit 0 locked |

## Verification
The hardest state to reach is the top entry code. The block must stay unlocked through 99999 good lines and lock on line 100000. The bench reaches it by holding the strobe high on every clock for the whole run and sampling just before and just after the final line. The bench also sweeps every other code for entry and exit, checking both the N-1 and N boundaries, and breaks runs one line short to show that the run restarts.

// File: rtl/vlq_pkg.sv
package vlq_pkg;

   localparam int unsigned LINES_MAX = 100000;

   typedef enum logic {
      ST_UNLOCKED = 1'b0,
      ST_LOCKED   = 1'b1
   } lock_st_e;

   function automatic int unsigned code_to_lines(input logic [2:0] code);
      int unsigned n;
      case (code)
         3'd0:    n = 1;
         3'd1:    n = 2;
         3'd2:    n = 5;
         3'd3:    n = 10;
         3'd4:    n = 100;
         3'd5:    n = 500;
         3'd6:    n = 1000;
         default: n = LINES_MAX;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/vlq_raw_mux.sv
module vlq_raw_mux #(
   parameter bit HAS_SC = 1'b1
) (
   input  logic fast_lock,
   input  logic slow_lock,
   input  logic src_fast,
   input  logic sc_need,
   input  logic sc_lock,
   output logic raw_ok
);
   logic src_ok;

   always_comb src_ok = src_fast ? fast_lock : slow_lock;

   generate
      if (HAS_SC) begin : g_sc
         always_comb raw_ok = src_ok && (!sc_need || sc_lock);
      end else begin : g_nosc
         logic sc_unused;
         always_comb sc_unused = sc_need ^ sc_lock;
         always_comb raw_ok = src_ok;
      end
   endgenerate

   always_comb begin
      if (src_fast && !fast_lock) AST_FAST_GATES: assert (!raw_ok); // R2
      if (!src_fast && !slow_lock) AST_SLOW_GATES: assert (!raw_ok); // R2
   end
endmodule

// File: rtl/vlq_run_counter.sv
module vlq_run_counter #(
   parameter int CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             hit,
   input  logic [CNT_W-1:0] target,
   output logic             done
);
   localparam int EXT_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [EXT_W-1:0] nxt;

   always_comb begin
      nxt  = {1'b0, cnt_q} + EXT_W'(1);
      done = step && hit && (nxt >= {1'b0, target});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (step) begin
         if (!hit || done) cnt_q <= '0;
         else              cnt_q <= nxt[CNT_W-1:0];
      end
   end

   AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(cnt_q)); // R6
   AST_CNT_BREAK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !hit) |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/vsync_lock_qual.sv
module vsync_lock_qual #(
   parameter int CNT_W  = 17,
   parameter bit HAS_SC = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_stb,
   input  logic       fast_lock,
   input  logic       slow_lock,
   input  logic       src_fast,
   input  logic       sc_need,
   input  logic       sc_lock,
   input  logic [2:0] enter_code,
   input  logic [2:0] exit_code,
   output logic [1:0] lock_status
);
   import vlq_pkg::*;

   localparam int MIN_W = $clog2(LINES_MAX + 1);

   generate
      if (CNT_W < MIN_W) begin : g_width_check
         $error("CNT_W too small for the longest run");
      end
   endgenerate

   lock_st_e         st_q;
   logic             raw_ok;
   logic             raw_q;
   logic             hit;
   logic             done;
   logic [CNT_W-1:0] target;

   vlq_raw_mux #(.HAS_SC(HAS_SC)) u_mux (
      .fast_lock (fast_lock),
      .slow_lock (slow_lock),
      .src_fast  (src_fast),
      .sc_need   (sc_need),
      .sc_lock   (sc_lock),
      .raw_ok    (raw_ok)
   );

   always_comb begin
      if (st_q == ST_LOCKED) begin
         hit    = !raw_ok;
         target = CNT_W'(code_to_lines(exit_code));
      end else begin
         hit    = raw_ok;
         target = CNT_W'(code_to_lines(enter_code));
      end
   end

   vlq_run_counter #(.CNT_W(CNT_W)) u_run (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (line_stb),
      .hit    (hit),
      .target (target),
      .done   (done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_UNLOCKED;
         raw_q <= 1'b0;
      end else if (line_stb) begin
         raw_q <= raw_ok;
         if (done) st_q <= (st_q == ST_LOCKED) ? ST_UNLOCKED : ST_LOCKED;
      end
   end

   always_comb lock_status = {raw_q, st_q == ST_LOCKED};

   AST_STATE_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      !line_stb |=> $stable(st_q)); // R6
   AST_ENTER_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_UNLOCKED && !(line_stb && raw_ok)) |=> (st_q == ST_UNLOCKED)); // R4
   AST_EXIT_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LOCKED && !(line_stb && !raw_ok)) |=> (st_q == ST_LOCKED)); // R5
   AST_RAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !line_stb |=> $stable(raw_q)); // R8
   AST_RAW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      line_stb |=> (raw_q == $past(raw_ok))); // R8
endmodule

// File: tb/vsync_lock_qual_test.sv
`timescale 1ns/1ps
module vsync_lock_qual_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_stb = 1'b0;
   logic       fast_lock = 1'b0;
   logic       slow_lock = 1'b0;
   logic       src_fast = 1'b1;
   logic       sc_need = 1'b0;
   logic       sc_lock = 1'b0;
   logic [2:0] enter_code = 3'd4;
   logic [2:0] exit_code = 3'd4;
   logic [1:0] lock_status;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   vsync_lock_qual uut (
      .clk(clk), .rst_n(rst_n), .line_stb(line_stb),
      .fast_lock(fast_lock), .slow_lock(slow_lock), .src_fast(src_fast),
      .sc_need(sc_need), .sc_lock(sc_lock),
      .enter_code(enter_code), .exit_code(exit_code),
      .lock_status(lock_status)
   );

   function automatic int lines_of(input int code);
      int tbl[8] = '{1, 2, 5, 10, 100, 500, 1000, 100000};
      return tbl[code];
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      line_stb = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // n strobed lines on the fast source with the given condition
   task automatic lines(input int n, input bit good);
      src_fast = 1'b1; sc_need = 1'b0;
      fast_lock = good; slow_lock = ~good;
      if (n > 0) begin
         line_stb = 1'b1;
         repeat (n) @(negedge clk);
         line_stb = 1'b0;
      end
   endtask

   task automatic one_line(input bit f, input bit s, input bit sel, input bit need, input bit sc);
      fast_lock = f; slow_lock = s; src_fast = sel; sc_need = need; sc_lock = sc;
      line_stb = 1'b1;
      @(negedge clk);
      line_stb = 1'b0;
   endtask

   initial begin : watchdog
      #(5.0 * 190000);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      chk("R1 in reset", lock_status, 0);
      do_reset();
      chk("R1 after reset", lock_status, 0);

      // R2/R3/R8 raw condition with a long entry run so no lock occurs
      enter_code = 3'd7;
      one_line(0, 1, 0, 0, 0); chk("R2 slow selected", lock_status[1], 1);
      one_line(0, 1, 1, 0, 0); chk("R2 fast selected", lock_status[1], 0);
      one_line(1, 0, 1, 0, 0); chk("R2 fast good", lock_status[1], 1);
      one_line(1, 0, 0, 0, 0); chk("R2 slow bad", lock_status[1], 0);
      one_line(1, 0, 1, 1, 0); chk("R3 subcarrier missing", lock_status[1], 0);
      one_line(1, 0, 1, 1, 1); chk("R3 subcarrier present", lock_status[1], 1);
      one_line(1, 0, 1, 0, 0); chk("R3 subcarrier not needed", lock_status[1], 1);
      fast_lock = 0; slow_lock = 0;
      repeat (5) @(negedge clk);
      chk("R8 raw held without strobe", lock_status[1], 1);

      // R4/R5 sweep over codes 0..6
      for (int c = 0; c < 7; c++) begin
         do_reset();
         enter_code = 3'(c); exit_code = 3'(c);
         lines(lines_of(c) - 1, 1'b1);
         chk($sformatf("R4 code %0d at N-1", c), lock_status[0], 0);
         lines(1, 1'b1);
         chk($sformatf("R4 code %0d at N", c), lock_status[0], 1);
         lines(lines_of(c) - 1, 1'b0);
         chk($sformatf("R5 code %0d at N-1", c), lock_status[0], 1);
         lines(1, 1'b0);
         chk($sformatf("R5 code %0d at N", c), lock_status[0], 0);
      end

      // R6: inputs good but no strobes
      do_reset();
      enter_code = 3'd1;
      lines(1, 1'b1);
      fast_lock = 1'b1;
      repeat (20) @(negedge clk);
      chk("R6 no strobe no lock", lock_status[0], 0);
      lines(1, 1'b1);
      chk("R6 run resumes", lock_status[0], 1);

      // R7: broken run restarts, both directions
      do_reset();
      enter_code = 3'd3; exit_code = 3'd2;
      lines(9, 1'b1); lines(1, 1'b0); lines(9, 1'b1);
      chk("R7 broken entry run", lock_status[0], 0);
      lines(1, 1'b1);
      chk("R7 full entry run", lock_status[0], 1);
      lines(4, 1'b0); lines(1, 1'b1); lines(4, 1'b0);
      chk("R7 broken exit run", lock_status[0], 1);
      lines(1, 1'b0);
      chk("R7 full exit run", lock_status[0], 0);

      // R4 top code, R5 long exit stays locked
      do_reset();
      enter_code = 3'd7; exit_code = 3'd7;
      lines(99999, 1'b1);
      chk("R4 code 7 at N-1", lock_status[0], 0);
      lines(1, 1'b1);
      chk("R4 code 7 at N", lock_status[0], 1);
      lines(1000, 1'b0);
      chk("R5 code 7 still locked", lock_status[0], 1);
      chk("R8 raw after bad line", lock_status[1], 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule